// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Snapshot FIFO

The block scans a key matrix of up to 16 rows and 8 columns. Scanning advances on a slow scan-rate tick, which is a one-cycle enable pulse inside the system clock domain. It pulls one row low at a time, and it samples the active-low column lines at the end of each row's window. Each complete pass over the matrix that finds at least one key closed produces a snapshot of up to eight pressed keys. The block stores each snapshot in a small FIFO as eight packed entry bytes.

A host reaches the block through a plain register port. Every write strobe and read strobe is accepted in the cycle it is given. There is no back-pressure, and reads are combinational. Through this port the host sets the control word, reads and clears the interrupt status, reads key entries and sets the per-row wake masks. Reading the upper entry word consumes the oldest snapshot. A single interrupt line combines a FIFO-level event with a keypress (wake) event.

Register map (word index on `reg_addr`): 0 control, 1 interrupt status, 2 entries 0..3, 3 entries 4..7 (pops), 4+r row mask for row r (bit 0).

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset all rows are high (inactive), `irq` is low, and the control and interrupt registers read zero.
- R2: Control bit 0 enables scanning. While it is clear, all rows are held high from the cycle after the write. A partial scan is discarded and no snapshot is stored.
- R3: After enable, the block waits 5 ticks with all rows high. It then drives rows 0 upward one at a time, each low for 16 + debounce ticks. After the last row it waits 5 ticks and repeats. At most one row is low at any time.
- R4: The debounce count is control bits 13:4 (10 bits) and lengthens every row window by that many ticks.
- R5: At the end of a pass in which some key was closed, one snapshot is stored. It lists the pressed keys in row order, then column order, and keeps the first 8. A pass with no key closed stores nothing.
- R6: Entry byte format: bit 7 valid, bits 6:3 row, bits 2:0 column. Entries 0..3 are read at index 2 and entries 4..7 at index 3, with entry k in bits 8k+7:8k of its word. Unused entries, and all entries while the FIFO is empty, read as zero.
- R7: Reading index 3 removes the oldest snapshot. Reading it while the FIFO is empty changes nothing.
- R8: The FIFO holds 4 snapshots. A snapshot that arrives while it is full is dropped, and the sticky overflow bit (interrupt bit 1) is set. Writing 1 to that bit clears it.
- R9: Interrupt register bits 7:4 give the number of stored snapshots.
- R10: FIFO status (interrupt bit 2) is set whenever the count is at least the threshold in control bits 17:14. A threshold of 0 never sets it. Writing 1 clears it only once the condition no longer holds.
- R11: Keypress status (interrupt bit 0) is set when control bit 1 is set and a closed key is sampled in a row whose mask bit is clear. Writing 1 clears it.
- R12: `irq` = (bit 2 AND control bit 3) OR (bit 0 AND control bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_tick | input | 1 | One-cycle scan-rate enable pulse |
| col_in_n | input | NUM_COLS | Column sense lines, low = key closed on driven row |
| row_out_n | output | NUM_ROWS | Row drive, low = row selected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on index 3) |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume three things about the inputs: the column lines are a function of the driven row alone, the key pattern does not change within a pass, and the host gives at most one strobe per cycle. The bench keeps within these limits. It models the matrix as a key map that is decoded from `row_out_n`. It changes that map only while scanning is disabled, and its register tasks issue single strobes. Random key maps and debounce values are mixed with directed cases for row timing, truncation at eight keys, overflow, threshold, masking and mid-scan disable.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int ENT_W     = 8;
  localparam int SNAP_KEYS = 8;
  localparam int SNAP_W    = ENT_W * SNAP_KEYS;

  typedef struct packed {
    logic [3:0]        n;
    logic [SNAP_W-1:0] ent;
  } snap_t;

  // Append the closed columns of one row, in column order, until full.
  function automatic snap_t snap_add(snap_t s, logic [3:0] row, logic [7:0] hits);
    snap_t r;
    r = s;
    for (int c = 0; c < 8; c++) begin
      if (hits[c] && r.n < 4'(SNAP_KEYS)) begin
        r.ent[ENT_W*r.n +: ENT_W] = {1'b1, row, 3'(c)};
        r.n = r.n + 4'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/kms_row_scanner.sv
module kms_row_scanner
  import kms_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int NUM_COLS  = 8,
  parameter int SCAN_T    = 16,
  parameter int START_DLY = 5,
  parameter int DEB_W     = 10,
  localparam int RW       = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic [DEB_W-1:0]    deb,
  input  logic [NUM_COLS-1:0] col_n,
  output logic [NUM_ROWS-1:0] row_n,
  output logic                samp_vld,
  output logic [RW-1:0]       samp_row,
  output logic                samp_hit,
  output logic                snap_vld,
  output snap_t               snap
);
  localparam int CNT_W = $clog2(SCAN_T + (1 << DEB_W));

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_ROW} st_e;
  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    row;
  snap_t            acc, merged;
  logic [7:0]       hits;
  logic [CNT_W-1:0] row_last;

  assign row_last = CNT_W'(SCAN_T - 1) + CNT_W'(deb);

  always_comb begin
    hits = '0;
    hits[NUM_COLS-1:0] = ~col_n;
    merged = snap_add(acc, 4'(row), hits);
  end

  always_comb begin
    row_n = '1;
    if (en && st == S_ROW) row_n[row] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; row <= '0; acc <= '0;
      samp_vld <= 1'b0; samp_row <= '0; samp_hit <= 1'b0;
      snap_vld <= 1'b0; snap <= '0;
    end else if (!en) begin
      st <= S_IDLE; cnt <= '0; row <= '0; acc <= '0;
      samp_vld <= 1'b0; snap_vld <= 1'b0;
    end else begin
      samp_vld <= 1'b0;
      snap_vld <= 1'b0;
      case (st)
        S_IDLE: begin st <= S_DLY; cnt <= '0; end
        S_DLY: if (tick) begin
          if (cnt == CNT_W'(START_DLY - 1)) begin
            st <= S_ROW; cnt <= '0; row <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: if (tick) begin
          if (cnt == row_last) begin
            cnt      <= '0;
            samp_vld <= 1'b1;
            samp_row <= row;
            samp_hit <= |hits;
            if (row == RW'(NUM_ROWS - 1)) begin
              st       <= S_DLY;
              acc      <= '0;
              snap     <= merged;
              snap_vld <= (merged.n != 4'd0);
            end else begin
              acc <= merged;
              row <= row + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~row_n)); // R3
  AST_STOP_NO_SNAP: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !snap_vld && !samp_vld); // R2
  AST_SNAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    snap_vld |-> samp_vld && samp_row == RW'(NUM_ROWS - 1)); // R5
endmodule

// File: rtl/kms_snap_fifo.sv
module kms_snap_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 68,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          dropped
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop, full;

  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && count != '0;
  assign do_push = push && (!full || do_pop);
  assign dropped = push && !do_push;
  assign dout    = mem[rp];

  always_ff @(posedge clk) if (do_push) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R8
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> count == CW'(DEPTH)); // R8
  AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    pop && count != '0 && !push |=> count == $past(count) - 1'b1); // R7
endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
  import kms_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 8,
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_tick,
  input  logic [NUM_COLS-1:0] col_in_n,
  output logic [NUM_ROWS-1:0] row_out_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq
);
  localparam int RW     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int DEB_W  = 10;
  localparam int MASK_0 = 4;

  logic [31:0]         ctrl_q;
  logic                st_kp, st_ovf, st_fifo;
  logic [NUM_ROWS-1:0] mask_q;
  logic                samp_vld, samp_hit, snap_vld, dropped, pop, fifo_cond;
  logic [RW-1:0]       samp_row;
  snap_t               snap, head;
  logic [CW-1:0]       fcnt;
  logic                wr_int;

  kms_row_scanner #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .DEB_W(DEB_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .tick(scan_tick), .deb(ctrl_q[13:4]),
    .col_n(col_in_n), .row_n(row_out_n), .samp_vld(samp_vld), .samp_row(samp_row),
    .samp_hit(samp_hit), .snap_vld(snap_vld), .snap(snap));

  assign pop = reg_rd && reg_addr == ADDR_W'(3);

  kms_snap_fifo #(.DEPTH(DEPTH), .W($bits(snap_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(snap_vld), .din(snap), .pop(pop),
    .dout(head), .count(fcnt), .dropped(dropped));

  assign fifo_cond = ctrl_q[17:14] != 4'd0 && 32'(fcnt) >= 32'(ctrl_q[17:14]);
  assign wr_int    = reg_wr && reg_addr == ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; st_kp <= 1'b0; st_ovf <= 1'b0; st_fifo <= 1'b0; mask_q <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(0)) ctrl_q <= reg_wdata;
      for (int r = 0; r < NUM_ROWS; r++)
        if (reg_wr && reg_addr == ADDR_W'(MASK_0 + r)) mask_q[r] <= reg_wdata[0];
      if (samp_vld && samp_hit && !mask_q[samp_row] && ctrl_q[1]) st_kp <= 1'b1;
      else if (wr_int && reg_wdata[0]) st_kp <= 1'b0;
      if (dropped) st_ovf <= 1'b1;
      else if (wr_int && reg_wdata[1]) st_ovf <= 1'b0;
      if (fifo_cond) st_fifo <= 1'b1;
      else if (wr_int && reg_wdata[2]) st_fifo <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(0): reg_rdata = ctrl_q;
      ADDR_W'(1): begin
        reg_rdata[7:4] = 4'(fcnt);
        reg_rdata[2]   = st_fifo;
        reg_rdata[1]   = st_ovf;
        reg_rdata[0]   = st_kp;
      end
      ADDR_W'(2): if (fcnt != '0) reg_rdata = head.ent[31:0];
      ADDR_W'(3): if (fcnt != '0) reg_rdata = head.ent[63:32];
      default:
        for (int r = 0; r < NUM_ROWS; r++)
          if (reg_addr == ADDR_W'(MASK_0 + r)) reg_rdata[0] = mask_q[r];
    endcase
  end

  assign irq = (st_fifo && ctrl_q[3]) || (st_kp && ctrl_q[1]);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> st_fifo || st_kp); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovf && !(wr_int && reg_wdata[1]) |=> st_ovf); // R8
  AST_KP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !st_kp && !(samp_vld && samp_hit) |=> !st_kp); // R11
endmodule

// File: tb/test_kbd_matrix_scan.sv
module test_kbd_matrix_scan;
  logic        clk = 1'b0, rst_n = 1'b0, scan_tick = 1'b0;
  logic [7:0]  col_in_n;
  logic [15:0] row_out_n;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  logic [7:0]  keys [16];
  int          tick_div = 1, tcnt = 0, checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  kbd_matrix_scan i_kbd_matrix_scan (.clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
    .col_in_n(col_in_n), .row_out_n(row_out_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always @(posedge clk) begin
    tcnt      <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    scan_tick <= (tcnt == 0);
  end

  always_comb begin
    col_in_n = '1;
    for (int r = 0; r < 16; r++) if (!row_out_n[r]) col_in_n = col_in_n & ~keys[r];
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 5'(a);
    #2 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [63:0] exp_snap();
    logic [63:0] e = '0;
    int n = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        if (keys[r][c] && n < 8) begin
          e[8*n +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    return e;
  endfunction

  task automatic clear_all();
    logic [31:0] d;
    wr(0, 0);
    for (int i = 0; i < 4; i++) rd(3, d);
    wr(1, 7);
    for (int r = 0; r < 16; r++) keys[r] = '0;
  endtask

  task automatic wait_snap(logic [31:0] ctrl_off);
    logic [31:0] d;
    do rd(1, d); while (d[7:4] == 4'd0);
    wr(0, ctrl_off);
  endtask

  task automatic read_snap(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(2, lo); rd(3, hi);
    s = {hi, lo};
  endtask

  task automatic meas_low(int r, output int len);
    do @(negedge clk); while (row_out_n[r] !== 1'b0);
    len = 0;
    while (row_out_n[r] === 1'b0) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] s;
    int len, gap, deb;
    void'($urandom(32'd1234));
    for (int r = 0; r < 16; r++) keys[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 rows", 64'(row_out_n), 64'hffff);
    chk("R1 irq", 64'(irq), 0);
    rd(0, d); chk("R1 ctrl", 64'(d), 0);
    rd(1, d); chk("R1 int", 64'(d), 0);
    rd(3, d); chk("R6 empty read", 64'(d), 0);

    // R3 R4 row timing with debounce 2
    wr(0, 32'h1 | (2 << 4));
    meas_low(0, len); chk("R4 row0 window", 64'(len), 18);
    chk("R3 row1 follows", 64'(row_out_n), 64'hfffd);
    meas_low(15, len); chk("R3 row15 window", 64'(len), 18);
    gap = 0;
    while (row_out_n[0] !== 1'b0) begin gap++; @(negedge clk); end
    chk("R3 start gap", 64'(gap), 5);
    wr(0, 0);
    rd(1, d); chk("R5 no keys no snapshot", 64'(d[7:4]), 0);

    // R3 slow tick
    tick_div = 3;
    wr(0, 1);
    meas_low(0, len); chk("R3 slow row window", 64'(len), 48);
    wr(0, 0);
    tick_div = 1;

    // R2 disable mid-scan
    clear_all();
    keys[1] = 8'h10; keys[9] = 8'h01;
    wr(0, 1);
    repeat (100) @(negedge clk);
    wr(0, 0);
    chk("R2 rows idle after disable", 64'(row_out_n), 64'hffff);
    repeat (400) @(negedge clk);
    rd(1, d); chk("R2 partial scan discarded", 64'(d[7:4]), 0);

    // R5 R6 truncation to eight keys
    clear_all();
    keys[0] = 8'h81; keys[4] = 8'hff; keys[15] = 8'h80;
    wr(0, 1 | (1 << 14));
    wait_snap(0);
    read_snap(s); chk("R5 first eight keys", s, exp_snap());
    rd(1, d); chk("R7 pop empties", 64'(d[7:4]), 0);

    // R5 R6 random key maps and debounce
    for (int it = 0; it < 20; it++) begin
      clear_all();
      for (int r = 0; r < 16; r++)
        keys[r] = (it % 2) ? 8'($urandom & $urandom & $urandom)
                           : 8'($urandom & $urandom & $urandom & $urandom);
      if (exp_snap() == 0) keys[$urandom % 16] = 8'h08;
      deb = $urandom % 4;
      wr(0, 1 | (deb << 4) | (1 << 14));
      wait_snap(0);
      read_snap(s); chk("R6 random snapshot", s, exp_snap());
    end

    // R8 overflow, R9 count
    clear_all();
    keys[2] = 8'h02;
    wr(0, 1);
    repeat (1700) @(negedge clk);
    wr(0, 0);
    rd(1, d);
    chk("R9 count full", 64'(d[7:4]), 4);
    chk("R8 overflow sticky", 64'(d[1]), 1);
    wr(1, 2);
    rd(1, d); chk("R8 overflow cleared", 64'(d[1]), 0);

    // R10 R12 threshold status
    wr(0, (3 << 14) | (1 << 3));
    rd(1, d); chk("R10 threshold reached", 64'(d[2]), 1);
    chk("R12 irq fifo", 64'(irq), 1);
    wr(1, 4);
    rd(1, d); chk("R10 status holds while at threshold", 64'(d[2]), 1);
    read_snap(s); chk("R6 stored snapshot", s, 64'h91);
    rd(3, d);
    wr(1, 4);
    rd(1, d);
    chk("R10 cleared below threshold", 64'(d[2]), 0);
    chk("R9 count two", 64'(d[7:4]), 2);
    chk("R12 irq low", 64'(irq), 0);

    // R11 masked row
    clear_all();
    wr(4 + 3, 1);
    rd(4 + 3, d); chk("R11 mask readback", 64'(d), 1);
    keys[3] = 8'h20;
    wr(0, 1 | 2 | (1 << 14));
    wait_snap(2);
    rd(1, d); chk("R11 masked row no keypress", 64'(d[0]), 0);
    chk("R12 irq masked", 64'(irq), 0);
    clear_all();
    wr(4 + 3, 0);
    keys[3] = 8'h20;
    wr(0, 1 | 2 | (1 << 14));
    wait_snap(2);
    rd(1, d); chk("R11 keypress set", 64'(d[0]), 1);
    chk("R12 irq keypress", 64'(irq), 1);
    wr(1, 1);
    rd(1, d); chk("R11 keypress cleared", 64'(d[0]), 0);
    chk("R12 irq released", 64'(irq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule